// File: doc/BRIEF.md
# Systolic Binary Threshold Correlator

The block compares a stored N-bit reference word against every N-bit window of a serial bitstream and produces one flag bit per window. It is a row of N identical bit-level cells. Each cell holds one reference bit, compares it with the stream bit that reaches it, and folds any mismatch into a partial distance. Each cell passes that distance to its neighbour through registers. The partial distance is not kept as a binary count. It travels as a two-bit code plus a sticky flag bit. The flag bit goes high once three mismatches have been seen, so a window raises its flag when its Hamming distance is three or more.

The reference word is shifted in serially, one bit per clock, while the load strobe is high. When the strobe is low the reference holds and correlation runs. The stream enters one bit per clock and moves along the row two register stages per cell, in the same direction as the partial results. Because of this skew each window is summed while it passes through the row. Once the row has filled with data taken outside any load, a valid flag leaves the array on every clock.

Top module: `systolic_threshold_correlator`

## Requirements
- R1: While reset is held and on the first clock after it is released, `flag_valid` and `flag_out` are 0.
- R2: On each clock edge with `ref_load` high, the reference shifts by one place toward cell 1, and `ref_bit` enters at cell N. After N load edges carrying bits b0..b(N-1) in that order, cell j holds b(j-1). On edges with `ref_load` low the reference is unchanged.
- R3: Let stream bits be numbered by the edge that captured them. For window k, cell j compares its reference bit with bit k+j-1. The window's flag is 1 exactly when the count of mismatching positions is 3 or more.
- R4: The flag for the window whose last bit is captured at edge n appears on `flag_out` after edge n+N.
- R5: After edge m, `flag_valid` is 1 exactly when the last 2N edges, m-2N+1 through m, all came after reset and all had `ref_load` low.
- R6: A clock edge with `ref_load` high drops `flag_valid` to 0 after that edge and restarts the 2N-edge fill.
- R7: Once valid, a new flag is produced on every clock while `ref_load` stays low.
- R8: A distance above 3, up to N, still flags 1. The sticky flag bit, once set in a cell, is carried into every cell that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_load | input | 1 | Reference shift strobe |
| ref_bit | input | 1 | Serial reference bit, enters at cell N |
| stream_bit | input | 1 | Serial data bit, one per clock |
| flag_out | output | 1 | Threshold flag of the window leaving cell 1 |
| flag_valid | output | 1 | `flag_out` belongs to a fully formed window |

## Verification
The assertions check on every cycle that the stored reference never moves without a load, and that a load edge always drops valid. They also check that valid only rises after exactly 2N clean run edges, that it stays high through uninterrupted running, and that a set sticky bit always moves on into the next cell. The scenarios show the things that only exist across windows: the pairing of reference bits with stream bits, the N-clock latency and the distance-three threshold. They cover directed patterns such as full match, full mismatch and alternating bits. Random streams with random mid-run reloads are also run, and every flag is compared with a directly computed Hamming distance.

// File: rtl/systolic_threshold_correlator.sv
module systolic_threshold_correlator #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_load,
  input  logic ref_bit,
  input  logic stream_bit,
  output logic flag_out,
  output logic flag_valid
);
  localparam int FILL = 2 * N;
  localparam int SKEW = FILL - 1;
  localparam int CW   = $clog2(FILL + 1);

  logic [N:1]      ref_q;
  logic [SKEW-1:0] pipe;
  logic [N:1]      h0_q, h1_q, s_q;
  logic [N:1]      h0_d, h1_d, s_d;
  logic [CW-1:0]   run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= '0;
    else if (ref_load) ref_q <= {ref_bit, ref_q[N:2]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else pipe <= {pipe[SKEW-2:0], stream_bit};
  end

  for (genvar j = 1; j <= N; j++) begin : g_cell
    logic mis, h0_i, h1_i, s_i;
    assign mis = ref_q[j] ^ pipe[2*(N-j)];
    if (j == N) begin : g_edge
      assign h0_i = 1'b0;
      assign h1_i = 1'b0;
      assign s_i  = 1'b0;
    end else begin : g_link
      assign h0_i = h0_q[j+1];
      assign h1_i = h1_q[j+1];
      assign s_i  = s_q[j+1];
    end
    assign h0_d[j] = h0_i | mis;
    assign h1_d[j] = h1_i ^ (mis & h0_i);
    assign s_d[j]  = s_i | (mis & h0_i & h1_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h0_q <= '0;
      h1_q <= '0;
      s_q  <= '0;
    end else begin
      h0_q <= h0_d;
      h1_q <= h1_d;
      s_q  <= s_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ref_load) run_cnt <= '0;
    else if (run_cnt != CW'(FILL)) run_cnt <= run_cnt + 1'b1;
  end

  assign flag_out   = s_q[1];
  assign flag_valid = (run_cnt == CW'(FILL));
endmodule

// File: rtl/correlator_checks.sv
module correlator_checks #(
  parameter int N = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_load,
  input logic       flag_valid,
  input logic [N:1] ref_q,
  input logic [N:1] s_q
);
  localparam int FILL = 2 * N;
  localparam int CW   = $clog2(FILL + 1);

  logic [CW-1:0] clean;
  always_ff @(posedge clk) begin
    if (!rst_n || ref_load) clean <= '0;
    else if (clean != CW'(FILL)) clean <= clean + 1'b1;
  end

  assert_ref_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_load |=> $stable(ref_q));

  assert_rise_after_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_valid) |-> clean == CW'(FILL));

  assert_load_drops_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_load |=> !flag_valid);

  assert_valid_persists_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_valid && !ref_load |=> flag_valid);

  for (genvar j = 1; j < N; j++) begin : g_sticky
    assert_sticky_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
      s_q[j+1] |=> s_q[j]);
  end
endmodule

bind systolic_threshold_correlator correlator_checks #(.N(N)) u_checks (
  .clk(clk), .rst_n(rst_n), .ref_load(ref_load), .flag_valid(flag_valid),
  .ref_q(ref_q), .s_q(s_q)
);

// File: tb/test_systolic_threshold_correlator.sv
module test_systolic_threshold_correlator;
  localparam int N = 4;
  localparam int FILL = 2 * N;
  localparam int HMAX = 8192;

  logic clk = 0, rst_n = 0, ref_load = 0, ref_bit = 0, stream_bit = 0;
  logic flag_out, flag_valid;

  systolic_threshold_correlator #(.N(N)) i_systolic_threshold_correlator (
    .clk(clk), .rst_n(rst_n), .ref_load(ref_load), .ref_bit(ref_bit),
    .stream_bit(stream_bit), .flag_out(flag_out), .flag_valid(flag_valid));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, edge_no = 0;
  bit done = 0;
  bit e_hist [HMAX];
  bit l_hist [HMAX];
  bit ref_m [1:N];

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edge_no);
    end
  endtask

  function automatic int exp_valid(int m);
    if (m < FILL) return 0;
    for (int i = m - FILL + 1; i <= m; i++) if (l_hist[i]) return 0;
    return 1;
  endfunction

  function automatic int window_dist(int m);
    int k = m - FILL + 1, d = 0;
    for (int j = 1; j <= N; j++) d += int'(ref_m[j] ^ e_hist[k + j - 1]);
    return d;
  endfunction

  task automatic step(bit ld, bit rb, bit sb);
    int ev, d;
    bit was_valid;
    ref_load = ld; ref_bit = rb; stream_bit = sb;
    was_valid = flag_valid;
    @(posedge clk);
    edge_no++;
    e_hist[edge_no] = sb;
    l_hist[edge_no] = ld;
    if (ld) begin
      for (int j = 1; j < N; j++) ref_m[j] = ref_m[j + 1];
      ref_m[N] = rb;
    end
    @(negedge clk);
    ev = exp_valid(edge_no);
    if (ld) check("R6", int'(flag_valid), 0);
    else if (was_valid) check("R7", int'(flag_valid), 1);
    else check("R5", int'(flag_valid), ev);
    if (ev == 1) begin
      d = window_dist(edge_no);
      if (d > 3) check("R8", int'(flag_out), 1);
      else check("R3 R4 R2", int'(flag_out), int'(d >= 3));
    end
  endtask

  task automatic load_word(bit [N-1:0] w);
    for (int i = 0; i < N; i++) step(1'b1, w[i], 1'b0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int j = 1; j <= N; j++) ref_m[j] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(flag_valid), 0);
    check("R1", int'(flag_out), 0);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    edge_no = 1;
    check("R1", int'(flag_valid), 0);
    check("R1", int'(flag_out), 0);

    load_word(4'b0101);
    for (int i = 0; i < 20; i++) step(0, 0, 1'b0);
    for (int i = 0; i < 20; i++) step(0, 0, 1'b1);
    for (int i = 0; i < 24; i++) step(0, 0, i[0]);
    for (int i = 0; i < 24; i++) step(0, 0, ~i[0]);
    load_word(4'b0000);
    for (int i = 0; i < 12; i++) step(0, 0, 1'b1);
    for (int i = 0; i < 16; i++) step(0, 0, (i % 5) == 0);
    load_word(4'b1111);
    for (int i = 0; i < 16; i++) step(0, 0, 1'b0);
    for (int i = 0; i < 16; i++) step(0, 0, i[1]);
    step(1, 1, 0);
    for (int i = 0; i < 12; i++) step(0, 0, $urandom_range(0, 1));

    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 59) == 0) load_word(N'($urandom()));
      else if ($urandom_range(0, 199) == 0) step(1, $urandom_range(0, 1), $urandom_range(0, 1));
      else step(0, 0, $urandom_range(0, 1));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule